// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Pin-Change Interrupts

This block is an eight-pin general-purpose I/O port. Software reaches it through two register views that share one set of state. The full view has direction and output registers, each with set, clear and toggle aliases. It also has an input register, an interrupt flag register and one control register per pin. The fast view is a compact four-register window onto the same direction, output, input and flag state. A write through either view changes the one shared register.

Each pin drives an output value and an output enable, and each pin offers a pull-up enable. External pin levels pass through a two-flop synchronizer. The input register then merges them with the driven values, so a pin configured as output reads back what it drives. Each pin has a three-bit sense mode. An input change that matches the mode sets that pin's flag. A level mode keeps the flag set while the input is low. The port interrupt request stays high while any flag is set.

Register access is a single-cycle bus with no handshake. A write takes effect at the clock edge where `bus_we` is high. A read returns data combinationally for the address currently presented.

Top module: `gpio_dualview_port`

## Requirements
- R1: After reset, direction, output, flags and every pin control register read as zero. `pad_oe`, `pad_out`, `pad_pull` and `irq` are all low.
- R2: With `bus_fast`=0, a write to offset 0x00 loads direction and a write to offset 0x04 loads output. The new values appear on `pad_oe` and `pad_out` in the cycle after the write edge, and they read back at the same offsets.
- R3: With `bus_fast`=0, the direction aliases sit at offsets 0x01, 0x02 and 0x03, and the output aliases at 0x05, 0x06 and 0x07. In each group the three offsets, in that order, OR the written mask into the register, clear the masked bits (AND-NOT), and XOR the mask into the register.
- R4: With `bus_fast`=1, offset 0x00 is direction, 0x01 is output, 0x02 is input and 0x03 is flags. These registers are the same ones the full view reaches, so a write through one view is visible in the other.
- R5: The input register (full offset 0x08, fast offset 0x02) reads (dir AND out) OR (NOT dir AND pin). Here pin is `pad_in` delayed by two clock edges.
- R6: Per-pin control registers sit at full offsets 0x10+n for pin n. Bits [2:0] select the sense mode and bit 3 drives `pad_pull[n]`. Reads return bits [3:0] with the upper bits zero, and written upper bits are dropped.
- R7: Sense mode 1 flags both edges, mode 2 flags rising edges and mode 3 flags falling edges of the effective input. The flag is readable at the third clock edge after a `pad_in` change.
- R8: Sense mode 5 sets the flag on every cycle the effective input is low, so a clear cannot remove the flag while the pin stays low.
- R9: Sense modes 0, 4, 6 and 7 never set a flag, whatever the input does.
- R10: Writing ones to full offset 0x09 or fast offset 0x03 clears those flag bits. Flag bits written as zero are unchanged. A flag set in the same cycle wins over the clear.
- R11: `irq` is high exactly while at least one flag bit is set. It drops in the cycle after the last flag is cleared.
- R12: Writes to the input register in either view are ignored. Reads of the alias offsets and of unmapped offsets (such as full 0x0A) return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_fast | input | 1 | View select: 1 for the fast view, 0 for the full view |
| bus_addr | input | 5 | Register offset within the selected view |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 8 | Write data or mask |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pad_in | input | 8 | External pin levels, asynchronous |
| pad_out | output | 8 | Driven pin values |
| pad_oe | output | 8 | Per-pin output enable (the direction register) |
| pad_pull | output | 8 | Per-pin pull-up enable |
| irq | output | 1 | Port interrupt request |

## Verification
Each result has a known cycle at which it is due:
- A register write is visible on the outputs and in read data right after the edge that takes it.
- A `pad_in` change reaches the input register after two edges.
- A change that matches a sense mode raises its flag and `irq` after three edges.
- A direction or output write that flips the effective input raises its flag after one edge.

The bench drives every input at a falling edge and samples shortly after. Table vectors that move pins wait four cycles before the next read. Directed checks then read the input and flag registers at one, two and three edges after a pin change, so early or late updates are caught.

// File: rtl/gpio_dualview_port.sv
module gpio_dualview_port #(
  parameter int W    = 8,
  parameter int AW   = 5,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_fast,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe,
  output logic [W-1:0]  pad_pull,
  output logic          irq
);

  localparam logic [AW-1:0] F_DIR    = AW'(5'h00);
  localparam logic [AW-1:0] F_DIRSET = AW'(5'h01);
  localparam logic [AW-1:0] F_DIRCLR = AW'(5'h02);
  localparam logic [AW-1:0] F_DIRTGL = AW'(5'h03);
  localparam logic [AW-1:0] F_OUT    = AW'(5'h04);
  localparam logic [AW-1:0] F_OUTSET = AW'(5'h05);
  localparam logic [AW-1:0] F_OUTCLR = AW'(5'h06);
  localparam logic [AW-1:0] F_OUTTGL = AW'(5'h07);
  localparam logic [AW-1:0] F_IN     = AW'(5'h08);
  localparam logic [AW-1:0] F_FLAGS  = AW'(5'h09);
  localparam int            F_CTRL0  = 16;
  localparam logic [AW-1:0] Q_DIR    = AW'(5'h00);
  localparam logic [AW-1:0] Q_OUT    = AW'(5'h01);
  localparam logic [AW-1:0] Q_IN     = AW'(5'h02);
  localparam logic [AW-1:0] Q_FLAGS  = AW'(5'h03);
  localparam int            CW       = 4;

  logic [W-1:0]      dir_q, out_q, flags_q, prev_q;
  logic [W-1:0]      dir_nx, out_nx, flag_clr, hit, pin_s, eff;
  logic [CW-1:0]     ctrl_q [W];
  logic [SYNC*W-1:0] sync_q;

  wire wr_full = bus_we & ~bus_fast;
  wire wr_fast = bus_we &  bus_fast;

  function automatic logic sense_hit(input logic [2:0] mode, input logic cur, input logic old);
    case (mode)
      3'd1:    return cur ^ old;
      3'd2:    return cur & ~old;
      3'd3:    return ~cur & old;
      3'd5:    return ~cur;
      default: return 1'b0;
    endcase
  endfunction

  always_comb begin
    dir_nx = dir_q;
    out_nx = out_q;
    if (wr_full) begin
      case (bus_addr)
        F_DIR:    dir_nx = bus_wdata;
        F_DIRSET: dir_nx = dir_q | bus_wdata;
        F_DIRCLR: dir_nx = dir_q & ~bus_wdata;
        F_DIRTGL: dir_nx = dir_q ^ bus_wdata;
        F_OUT:    out_nx = bus_wdata;
        F_OUTSET: out_nx = out_q | bus_wdata;
        F_OUTCLR: out_nx = out_q & ~bus_wdata;
        F_OUTTGL: out_nx = out_q ^ bus_wdata;
        default: ;
      endcase
    end
    if (wr_fast && bus_addr == Q_DIR) dir_nx = bus_wdata;
    if (wr_fast && bus_addr == Q_OUT) out_nx = bus_wdata;
  end

  assign flag_clr = ((wr_full && bus_addr == F_FLAGS) || (wr_fast && bus_addr == Q_FLAGS))
                    ? bus_wdata : '0;

  assign pin_s = sync_q[SYNC*W-1 -: W];
  assign eff   = (dir_q & out_q) | (~dir_q & pin_s);

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_pin
      assign hit[g]      = sense_hit(ctrl_q[g][2:0], eff[g], prev_q[g]);
      assign pad_pull[g] = ctrl_q[g][3];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q   <= '0;
      out_q   <= '0;
      flags_q <= '0;
      prev_q  <= '0;
      sync_q  <= '0;
      for (int i = 0; i < W; i++) ctrl_q[i] <= '0;
    end else begin
      dir_q   <= dir_nx;
      out_q   <= out_nx;
      prev_q  <= eff;
      sync_q  <= {sync_q[(SYNC-1)*W-1:0], pad_in};
      flags_q <= (flags_q & ~flag_clr) | hit;
      for (int i = 0; i < W; i++)
        if (wr_full && bus_addr == AW'(F_CTRL0 + i)) ctrl_q[i] <= bus_wdata[CW-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_fast) begin
      case (bus_addr)
        Q_DIR:   bus_rdata = dir_q;
        Q_OUT:   bus_rdata = out_q;
        Q_IN:    bus_rdata = eff;
        Q_FLAGS: bus_rdata = flags_q;
        default: ;
      endcase
    end else begin
      case (bus_addr)
        F_DIR:   bus_rdata = dir_q;
        F_OUT:   bus_rdata = out_q;
        F_IN:    bus_rdata = eff;
        F_FLAGS: bus_rdata = flags_q;
        default: ;
      endcase
      for (int i = 0; i < W; i++)
        if (bus_addr == AW'(F_CTRL0 + i)) bus_rdata = {{(W-CW){1'b0}}, ctrl_q[i]};
    end
  end

  assign pad_out = out_q;
  assign pad_oe  = dir_q;
  assign irq     = |flags_q;

  logic [W-1:0] quiet;
  generate
    for (g = 0; g < W; g++) begin : g_quiet
      assign quiet[g] = !(ctrl_q[g][2:0] inside {3'd1, 3'd2, 3'd3, 3'd5});
    end
  endgenerate

  AST_QUIET_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & ~$past(flags_q) & $past(quiet)) == '0)); // R9
  AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & $past(hit)) == $past(hit))); // R7 R8
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_clr & ~hit) != '0) |=> ((flags_q & $past(flag_clr & ~hit)) == '0)); // R10
  AST_OUTSET_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_full && bus_addr == F_OUTSET) |=> ((pad_out & $past(bus_wdata)) == $past(bus_wdata))); // R3
  AST_OUTCLR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_full && bus_addr == F_OUTCLR) |=> ((pad_out & $past(bus_wdata)) == '0)); // R3
  AST_FAST_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fast && bus_addr == Q_DIR) |=> (pad_oe == $past(bus_wdata))); // R4
  AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> ($past(flag_clr) != '0)); // R11

endmodule

// File: tb/gpio_dualview_port_tb.sv
module gpio_dualview_port_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_fast = 1'b0;
  logic [4:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_out, pad_oe, pad_pull;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  gpio_dualview_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_fast(bus_fast), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pull(pad_pull), .irq(irq)
  );

  // fields: req[27:24] op[23:21] addr[20:16] data[15:8] exp[7:0]
  // op: 0 write full, 1 write fast, 2 read full, 3 read fast, 4 set pins and wait
  localparam int NV = 61;
  localparam logic [27:0] VEC [NV] = '{
    {4'd1, 3'd2, 5'h00, 8'h00, 8'h00},  // R1
    {4'd1, 3'd2, 5'h09, 8'h00, 8'h00},  // R1
    {4'd1, 3'd2, 5'h17, 8'h00, 8'h00},  // R1
    {4'd2, 3'd0, 5'h00, 8'hF0, 8'h00},  // R2
    {4'd4, 3'd3, 5'h00, 8'h00, 8'hF0},  // R4
    {4'd2, 3'd0, 5'h04, 8'hAA, 8'h00},  // R2
    {4'd4, 3'd3, 5'h01, 8'h00, 8'hAA},  // R4
    {4'd3, 3'd0, 5'h05, 8'h05, 8'h00},  // R3
    {4'd3, 3'd2, 5'h04, 8'h00, 8'hAF},  // R3
    {4'd3, 3'd0, 5'h06, 8'h0F, 8'h00},  // R3
    {4'd3, 3'd2, 5'h04, 8'h00, 8'hA0},  // R3
    {4'd3, 3'd0, 5'h07, 8'hFF, 8'h00},  // R3
    {4'd3, 3'd2, 5'h04, 8'h00, 8'h5F},  // R3
    {4'd3, 3'd0, 5'h01, 8'h0C, 8'h00},  // R3
    {4'd3, 3'd2, 5'h00, 8'h00, 8'hFC},  // R3
    {4'd3, 3'd0, 5'h02, 8'h30, 8'h00},  // R3
    {4'd3, 3'd2, 5'h00, 8'h00, 8'hCC},  // R3
    {4'd3, 3'd0, 5'h03, 8'hFF, 8'h00},  // R3
    {4'd3, 3'd2, 5'h00, 8'h00, 8'h33},  // R3
    {4'd4, 3'd1, 5'h00, 8'h0F, 8'h00},  // R4
    {4'd4, 3'd2, 5'h00, 8'h00, 8'h0F},  // R4
    {4'd4, 3'd1, 5'h01, 8'h3C, 8'h00},  // R4
    {4'd4, 3'd2, 5'h04, 8'h00, 8'h3C},  // R4
    {4'd5, 3'd4, 5'h00, 8'hA5, 8'h00},  // R5
    {4'd5, 3'd2, 5'h08, 8'h00, 8'hAC},  // R5
    {4'd5, 3'd3, 5'h02, 8'h00, 8'hAC},  // R5
    {4'd12, 3'd1, 5'h02, 8'hFF, 8'h00}, // R12
    {4'd12, 3'd2, 5'h08, 8'h00, 8'hAC}, // R12
    {4'd12, 3'd2, 5'h00, 8'h00, 8'h0F}, // R12
    {4'd12, 3'd2, 5'h04, 8'h00, 8'h3C}, // R12
    {4'd12, 3'd0, 5'h08, 8'h00, 8'h00}, // R12
    {4'd12, 3'd2, 5'h08, 8'h00, 8'hAC}, // R12
    {4'd12, 3'd2, 5'h0A, 8'h00, 8'h00}, // R12
    {4'd2, 3'd0, 5'h00, 8'h00, 8'h00},  // R2
    {4'd6, 3'd0, 5'h10, 8'h0A, 8'h00},  // R6
    {4'd6, 3'd0, 5'h11, 8'h03, 8'h00},  // R6
    {4'd6, 3'd0, 5'h12, 8'h01, 8'h00},  // R6
    {4'd6, 3'd0, 5'h13, 8'h04, 8'h00},  // R6
    {4'd6, 3'd0, 5'h14, 8'h06, 8'h00},  // R6
    {4'd6, 3'd0, 5'h15, 8'h07, 8'h00},  // R6
    {4'd6, 3'd0, 5'h16, 8'h00, 8'h00},  // R6
    {4'd6, 3'd0, 5'h17, 8'h05, 8'h00},  // R6
    {4'd6, 3'd2, 5'h10, 8'h00, 8'h0A},  // R6
    {4'd6, 3'd2, 5'h17, 8'h00, 8'h05},  // R6
    {4'd6, 3'd0, 5'h10, 8'hFA, 8'h00},  // R6
    {4'd6, 3'd2, 5'h10, 8'h00, 8'h0A},  // R6
    {4'd9, 3'd2, 5'h09, 8'h00, 8'h00},  // R9
    {4'd7, 3'd4, 5'h00, 8'h5A, 8'h00},  // R7 R8 R9
    {4'd7, 3'd2, 5'h09, 8'h00, 8'h84},  // R7
    {4'd10, 3'd0, 5'h09, 8'h04, 8'h00}, // R10
    {4'd10, 3'd2, 5'h09, 8'h00, 8'h80}, // R10
    {4'd8, 3'd0, 5'h09, 8'h80, 8'h00},  // R8
    {4'd8, 3'd2, 5'h09, 8'h00, 8'h80},  // R8
    {4'd7, 3'd4, 5'h00, 8'hA5, 8'h00},  // R7
    {4'd7, 3'd2, 5'h09, 8'h00, 8'h87},  // R7
    {4'd10, 3'd1, 5'h03, 8'h80, 8'h00}, // R10
    {4'd10, 3'd3, 5'h03, 8'h00, 8'h07}, // R10
    {4'd10, 3'd0, 5'h09, 8'h03, 8'h00}, // R10
    {4'd10, 3'd2, 5'h09, 8'h00, 8'h04}, // R10
    {4'd10, 3'd0, 5'h09, 8'h04, 8'h00}, // R10
    {4'd10, 3'd2, 5'h09, 8'h00, 8'h00}  // R10
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic f, input logic [4:0] a, input logic [7:0] d);
    bus_fast = f; bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic f, input logic [4:0] a, input logic [7:0] exp, input string tag);
    bus_fast = f; bus_addr = a;
    #2;
    chk(tag, bus_rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 pad_out", pad_out, 8'h00);
    chk("R1 pad_pull", pad_pull, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [27:0] v;
      v = VEC[i];
      case (v[23:21])
        3'd0: wr(1'b0, v[20:16], v[15:8]);
        3'd1: wr(1'b1, v[20:16], v[15:8]);
        3'd2, 3'd3: begin
          bus_fast = v[21]; bus_addr = v[20:16];
          #2;
          n_chk++;
          if (bus_rdata !== v[7:0]) begin
            n_bad++;
            $display("FAIL R%0d vector %0d: got %02h expected %02h", v[27:24], i, bus_rdata, v[7:0]);
          end
          @(negedge clk);
        end
        default: begin
          pad_in = v[15:8];
          repeat (4) @(negedge clk);
        end
      endcase
    end

    chk("R11 irq idle", {7'd0, irq}, 8'h00);
    pad_in = 8'hA1;
    repeat (4) @(negedge clk);
    chk("R11 irq raised", {7'd0, irq}, 8'h01);
    rd(1'b0, 5'h09, 8'h04, "R7 both-edge fall");
    @(negedge clk);
    wr(1'b0, 5'h09, 8'h04);
    chk("R11 irq dropped", {7'd0, irq}, 8'h00);

    pad_in = 8'hA5;
    @(negedge clk);
    rd(1'b0, 5'h08, 8'hA1, "R5 one edge");
    @(negedge clk);
    rd(1'b0, 5'h08, 8'hA5, "R5 two edges");
    rd(1'b0, 5'h09, 8'h00, "R7 flag not before third edge");
    @(negedge clk);
    rd(1'b0, 5'h09, 8'h04, "R7 flag at third edge");

    chk("R6 pad_pull", pad_pull, 8'h01);

    @(negedge clk);
    wr(1'b0, 5'h00, 8'hFF);
    chk("R2 pad_oe", pad_oe, 8'hFF);
    wr(1'b0, 5'h04, 8'h96);
    chk("R2 pad_out", pad_out, 8'h96);
    rd(1'b0, 5'h08, 8'h96, "R5 output readback");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule